// File: doc/BRIEF.md
# Aperture Phase Calibration Controller

This block is the digital half of the calibration for the injection aperture of a multiplying clock loop. A 4-bit rotator code places the reference-injection select pulse at one of sixteen evenly spaced phases that together cover one whole oscillator period. After a start request the controller steps the code upward from zero. At each code it lets the analog path settle for a programmable number of cycles. It then adds up the magnitudes of a fixed power-of-two number of signed duty-cycle-error readings. That sum stands in for the period jitter seen at that phase.

After the last code the controller drives the code with the smallest sum onto the rotator and keeps it there until a new sweep is started. A one-cycle done pulse marks the end of the sweep. The block also holds the loop's injection-strength setting. This is a 3-bit value in steps of 20%: 0 means pure phase-locked operation and 5 means full reference injection. Writes above the top setting are clamped.

Top module: `aperture_cal_ctrl`

## Requirements
- R1: After synchronous reset the block is idle with rot_code = 0, best_code = 0, done = 0 and inj_level = 0.
- R2: A start pulse while idle begins a sweep. rot_code reads 0 on the cycle after that edge and then rises by exactly one per code step, through all 16 codes (0 to 15), which together span one oscillator period.
- R3: After each code is applied, err_valid is ignored for settle_cycles + 1 clock cycles, counted from the cycle the new code first appears on rot_code. rot_code does not change during that window.
- R4: Once the settle window has passed, the block takes exactly 2^AVG_LOG2 samples with err_valid high (4 by default). It adds the absolute values of the two's-complement err_data samples. The most negative input, -128, counts as 128.
- R5: The winning code is the one with the smallest sum. If two codes have equal sums, the lower code wins.
- R6: On the clock edge that accepts the last sample of code 15, done goes high for exactly one cycle. From that cycle on, rot_code equals best_code and stays constant until the next accepted start.
- R7: A start pulse during a sweep is ignored: the sweep neither restarts nor jumps.
- R8: A write with inj_wr stores inj_wdata on the next cycle when it is 0 to 5. Values 6 and 7 are stored as 5. Setting k means 20·k percent injection.
- R9: best_code is cleared to 0 when a sweep starts. During the sweep it shows the best code among the codes finished so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a sweep when idle |
| settle_cycles | input | 6 | Settle wait per code, minus one |
| err_valid | input | 1 | Strobe for err_data |
| err_data | input | 8 | Signed duty-cycle error sample |
| inj_wr | input | 1 | Write strobe for the injection strength |
| inj_wdata | input | 3 | Requested injection strength |
| inj_level | output | 3 | Stored injection strength, 0 to 5 |
| rot_code | output | 4 | Phase-rotator code |
| best_code | output | 4 | Best code found so far / final result |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench feeds error sequences in which one phase clearly wins, two phases tie exactly, and every reading is -128 except at one phase. A design that breaks ties toward the later code, or that takes the magnitude of -128 with too few bits, picks the wrong phase. During each settle window the bench drives zero-valued readings, so a controller that samples too early sees a false minimum and finishes on the wrong code. Extra start pulses in the middle of a sweep and out-of-range strength writes of 6 and 7 catch a sweep that restarts and a register that wraps instead of clamping.

// File: rtl/aps_pkg.sv
package aps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SETTLE  = 2'd1,
      ST_COLLECT = 2'd2
   } cal_state_e;
endpackage

// File: rtl/aps_err_accum.sv
module aps_err_accum #(
   parameter int ERR_W    = 8,
   parameter int AVG_LOG2 = 2,
   localparam int SUM_W   = ERR_W + AVG_LOG2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clear,
   input  logic                    take,
   input  logic signed [ERR_W-1:0] err_in,
   output logic [SUM_W-1:0]        sum_out,
   output logic                    last_out
);
   logic [ERR_W-1:0]    raw;
   logic [ERR_W-1:0]    mag;
   logic [SUM_W-1:0]    acc_q;
   logic [AVG_LOG2-1:0] cnt_q;

   generate
      if (ERR_W < 2) begin : g_bad_err_w
         $error("aps_err_accum: ERR_W must be at least 2");
      end
      if (AVG_LOG2 < 1 || AVG_LOG2 > 8) begin : g_bad_avg
         $error("aps_err_accum: AVG_LOG2 must be within 1..8");
      end
   endgenerate

   // magnitude fits in ERR_W unsigned bits, including the most negative value
   assign raw      = err_in;
   assign mag      = raw[ERR_W-1] ? (~raw + 1'b1) : raw;
   assign sum_out  = acc_q + SUM_W'(mag);
   assign last_out = &cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         acc_q <= '0;
         cnt_q <= '0;
      end else if (take) begin
         if (last_out) begin
            acc_q <= '0;
            cnt_q <= '0;
         end else begin
            acc_q <= sum_out;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/aps_min_track.sv
module aps_min_track #(
   parameter int CODE_W = 4,
   parameter int VAL_W  = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              cand_en,
   input  logic [VAL_W-1:0]  cand_val,
   input  logic [CODE_W-1:0] cand_code,
   output logic              win,
   output logic [CODE_W-1:0] best_code
);
   logic [VAL_W-1:0]  best_val_q;
   logic [CODE_W-1:0] best_code_q;

   generate
      if (CODE_W < 1) begin : g_bad_code_w
         $error("aps_min_track: CODE_W must be positive");
      end
   endgenerate

   // strict compare: an equal later candidate never replaces an earlier one
   assign win       = cand_val < best_val_q;
   assign best_code = best_code_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         best_val_q  <= '1;
         best_code_q <= '0;
      end else if (cand_en && win) begin
         best_val_q  <= cand_val;
         best_code_q <= cand_code;
      end
   end
endmodule

// File: rtl/aps_inj_reg.sv
module aps_inj_reg #(
   parameter int INJ_W   = 3,
   parameter int INJ_MAX = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr,
   input  logic [INJ_W-1:0] wdata,
   output logic [INJ_W-1:0] level
);
   localparam logic [INJ_W-1:0] TOP = INJ_W'(INJ_MAX);
   logic [INJ_W-1:0] level_q;

   generate
      if (INJ_MAX < 1 || INJ_MAX >= (1 << INJ_W)) begin : g_bad_max
         $error("aps_inj_reg: INJ_MAX must fit in INJ_W bits");
      end
   endgenerate

   assign level = level_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
      end else if (wr) begin
         level_q <= (wdata > TOP) ? TOP : wdata;
      end
   end
endmodule

// File: rtl/aperture_cal_ctrl.sv
module aperture_cal_ctrl #(
   parameter int CODE_W   = 4,
   parameter int ERR_W    = 8,
   parameter int AVG_LOG2 = 2,
   parameter int SETTLE_W = 6,
   parameter int INJ_W    = 3,
   parameter int INJ_MAX  = 5
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    start,
   input  logic [SETTLE_W-1:0]     settle_cycles,
   input  logic                    err_valid,
   input  logic signed [ERR_W-1:0] err_data,
   input  logic                    inj_wr,
   input  logic [INJ_W-1:0]        inj_wdata,
   output logic [INJ_W-1:0]        inj_level,
   output logic [CODE_W-1:0]       rot_code,
   output logic [CODE_W-1:0]       best_code,
   output logic                    done
);
   import aps_pkg::*;

   localparam int SUM_W = ERR_W + AVG_LOG2;
   localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};

   generate
      if (SETTLE_W < 1) begin : g_bad_settle
         $error("aperture_cal_ctrl: SETTLE_W must be positive");
      end
   endgenerate

   cal_state_e          state_q;
   logic [CODE_W-1:0]   code_q;
   logic [CODE_W-1:0]   hold_q;
   logic [SETTLE_W-1:0] settle_q;
   logic                done_q;

   logic                take;
   logic                last_sample;
   logic                final_sample;
   logic                clear_acc;
   logic                clear_best;
   logic [SUM_W-1:0]    sum_w;
   logic                win_w;
   logic [CODE_W-1:0]   best_w;

   assign take         = (state_q == ST_COLLECT) && err_valid;
   assign final_sample = take && last_sample;
   assign clear_acc    = (state_q != ST_COLLECT);
   assign clear_best   = (state_q == ST_IDLE) && start;

   aps_err_accum #(.ERR_W(ERR_W), .AVG_LOG2(AVG_LOG2)) u_accum (
      .clk      (clk),
      .rst      (rst),
      .clear    (clear_acc),
      .take     (take),
      .err_in   (err_data),
      .sum_out  (sum_w),
      .last_out (last_sample)
   );

   aps_min_track #(.CODE_W(CODE_W), .VAL_W(SUM_W)) u_min (
      .clk       (clk),
      .rst       (rst),
      .clear     (clear_best),
      .cand_en   (final_sample),
      .cand_val  (sum_w),
      .cand_code (code_q),
      .win       (win_w),
      .best_code (best_w)
   );

   aps_inj_reg #(.INJ_W(INJ_W), .INJ_MAX(INJ_MAX)) u_inj (
      .clk   (clk),
      .rst   (rst),
      .wr    (inj_wr),
      .wdata (inj_wdata),
      .level (inj_level)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         code_q   <= '0;
         hold_q   <= '0;
         settle_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q  <= ST_SETTLE;
                  code_q   <= '0;
                  settle_q <= '0;
               end
            end
            ST_SETTLE: begin
               if (settle_q == settle_cycles) begin
                  state_q <= ST_COLLECT;
               end else begin
                  settle_q <= settle_q + 1'b1;
               end
            end
            ST_COLLECT: begin
               if (final_sample) begin
                  if (code_q == LAST_CODE) begin
                     state_q <= ST_IDLE;
                     hold_q  <= win_w ? code_q : best_w;
                     done_q  <= 1'b1;
                  end else begin
                     state_q  <= ST_SETTLE;
                     code_q   <= code_q + 1'b1;
                     settle_q <= '0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rot_code  = (state_q == ST_IDLE) ? hold_q : code_q;
   assign best_code = best_w;
   assign done      = done_q;
endmodule

// File: rtl/aps_cal_checker.sv
module aps_cal_checker #(
   parameter int CODE_W  = 4,
   parameter int INJ_W   = 3,
   parameter int INJ_MAX = 5
) (
   input logic                clk,
   input logic                rst,
   input logic                start,
   input logic                inj_wr,
   input logic [INJ_W-1:0]    inj_wdata,
   input logic [INJ_W-1:0]    inj_level,
   input logic [CODE_W-1:0]   rot_code,
   input logic [CODE_W-1:0]   best_code,
   input logic                done,
   input aps_pkg::cal_state_e state_q
);
   import aps_pkg::*;

   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   // R1
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (rot_code == '0 && best_code == '0 && !done && inj_level == '0));

   // R2
   a_r2_code_step: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_COLLECT) |=>
         (state_q != ST_SETTLE) || (rot_code == CODE_W'($past(rot_code) + 1'b1)));

   // R3
   a_r3_settle_stable: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SETTLE) |=> $stable(rot_code));

   // R6
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r6_done_best: assert property (@(posedge clk) disable iff (rst)
      done |-> (rot_code == best_code));

   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && !start) |=> $stable(rot_code));

   // R7
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_IDLE && start) |=> (state_q != ST_IDLE) || done);

   // R8
   a_r8_clamp: assert property (@(posedge clk) disable iff (rst)
      (inj_wr && inj_wdata > INJ_W'(INJ_MAX)) |=> (inj_level == INJ_W'(INJ_MAX)));

   a_r8_store: assert property (@(posedge clk) disable iff (rst)
      (inj_wr && inj_wdata <= INJ_W'(INJ_MAX)) |=> (inj_level == $past(inj_wdata)));

   a_r8_range: assert property (@(posedge clk) disable iff (rst)
      inj_level <= INJ_W'(INJ_MAX));
endmodule

bind aperture_cal_ctrl aps_cal_checker #(
   .CODE_W (CODE_W),
   .INJ_W  (INJ_W),
   .INJ_MAX(INJ_MAX)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .inj_wr    (inj_wr),
   .inj_wdata (inj_wdata),
   .inj_level (inj_level),
   .rot_code  (rot_code),
   .best_code (best_code),
   .done      (done),
   .state_q   (state_q)
);

// File: tb/sim_aperture_cal_ctrl.sv
module sim_aperture_cal_ctrl;
   localparam int NSAMP = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              start = 1'b0;
   logic [5:0]        settle_cycles = '0;
   logic              err_valid = 1'b0;
   logic signed [7:0] err_data = '0;
   logic              inj_wr = 1'b0;
   logic [2:0]        inj_wdata = '0;
   logic [2:0]        inj_level;
   logic [3:0]        rot_code;
   logic [3:0]        best_code;
   logic              done;

   always #10 clk = ~clk;

   aperture_cal_ctrl u0 (
      .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
      .err_valid(err_valid), .err_data(err_data), .inj_wr(inj_wr),
      .inj_wdata(inj_wdata), .inj_level(inj_level), .rot_code(rot_code),
      .best_code(best_code), .done(done)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_st = 0, m_code = 0, m_hold = 0, m_best = 0, m_bestv = 0;
   int m_done = 0, m_inj = 0, m_sc = 0, m_n = 0, m_acc = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_st = 0; m_code = 0; m_hold = 0; m_best = 0; m_bestv = 1 << 30;
         m_done = 0; m_inj = 0; m_sc = 0; m_n = 0; m_acc = 0;
      end else begin
         int e, a, nb;
         m_done = 0;
         if (inj_wr) m_inj = (int'(inj_wdata) > 5) ? 5 : int'(inj_wdata);
         if (m_st == 0) begin
            if (start) begin
               m_st = 1; m_code = 0; m_sc = 0; m_best = 0; m_bestv = 1 << 30;
            end
         end else if (m_st == 1) begin
            if (m_sc == int'(settle_cycles)) begin
               m_st = 2; m_n = 0; m_acc = 0;
            end else m_sc++;
         end else if (err_valid) begin
            e = int'(err_data);
            a = m_acc + ((e < 0) ? -e : e);
            if (m_n == NSAMP - 1) begin
               nb = m_best;
               if (a < m_bestv) begin m_bestv = a; m_best = m_code; nb = m_code; end
               if (m_code == 15) begin
                  m_st = 0; m_hold = nb; m_done = 1;
               end else begin
                  m_code++; m_st = 1; m_sc = 0;
               end
            end else begin
               m_acc = a; m_n++;
            end
         end
      end
   end

   // compare on every falling edge once reset is released
   logic cmp_en = 1'b0;
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R2", "rot_code vs model", int'(rot_code), (m_st == 0) ? m_hold : m_code);
         chk("R9", "best_code vs model", int'(best_code), m_best);
         chk("R6", "done vs model", int'(done), m_done);
         chk("R8", "inj_level vs model", int'(inj_level), m_inj);
      end
   end

   // ---------------- error-reading source ----------------
   int scen = 0;
   int vmode = 0;
   int since = 0;
   int prev_rot = 0;
   int vcnt = 0;
   int kk = 0;

   function automatic int pat(int s, int c, int k);
      int d;
      case (s)
         0: begin d = (c > 9) ? c - 9 : 9 - c; return ((k % 2) ? -1 : 1) * (d * 6 + (k % 3)); end
         1: begin
               d = (c > 3) ? c - 3 : 3 - c;
               if (((c > 12) ? c - 12 : 12 - c) < d) d = (c > 12) ? c - 12 : 12 - c;
               return ((k % 2) ? -1 : 1) * (d * 10 + 2);
            end
         2: return (c == 7) ? 127 : -128;
         default: return ((c * 37 + k * 5) % 23) - 11 + ((c == 5) ? 0 : 40);
      endcase
   endfunction

   always @(negedge clk) begin
      if (int'(rot_code) != prev_rot) since = 0; else since++;
      prev_rot = int'(rot_code);
      vcnt++;
      err_valid = (vmode == 1) ? 1'b1 : ((vcnt % 3) != 1);
      // zero readings inside the settle window would win if sampled (R3)
      if (since <= int'(settle_cycles)) err_data = 8'sd0;
      else err_data = 8'(pat(scen, int'(rot_code), kk));
      if (err_valid) kk++;
   end

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
   endtask

   task automatic sweep(int s, int settle, int vm, int exp_best, string tag);
      bit ok;
      scen = s; vmode = vm; settle_cycles = 6'(settle);
      pulse_start();
      wait_done(ok);
      chk("R6", "done seen", int'(ok), 1);
      chk(tag, "best_code at done", int'(best_code), exp_best);
      chk("R6", "rot_code at done", int'(rot_code), exp_best);
      repeat (4) @(negedge clk);
      chk("R6", "rot_code held", int'(rot_code), exp_best);
   endtask

   initial begin
      bit ok;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      cmp_en = 1'b1;
      chk("R1", "reset rot_code", int'(rot_code), 0);
      chk("R1", "reset best_code", int'(best_code), 0);
      chk("R1", "reset done", int'(done), 0);
      chk("R1", "reset inj_level", int'(inj_level), 0);

      // R8: every strength value, 6 and 7 clamp to 5
      for (int v = 0; v < 8; v++) begin
         @(negedge clk); inj_wr = 1'b1; inj_wdata = 3'(v);
         @(negedge clk); inj_wr = 1'b0;
         chk("R8", "inj_level after write", int'(inj_level), (v > 5) ? 5 : v);
      end

      // R5 clear minimum, R3 settle window guarding
      sweep(0, 3, 0, 9, "R5");
      // R5 tie between codes 3 and 12 keeps the lower one
      sweep(1, 1, 0, 3, "R5");
      // R4 most negative reading counts as 128; back-to-back valid, no settle
      sweep(2, 0, 1, 7, "R4");

      // R7 extra start pulses mid-sweep, with a clamp write in flight
      scen = 3; vmode = 0; settle_cycles = 6'd2;
      pulse_start();
      repeat (20) @(negedge clk);
      start = 1'b1; inj_wr = 1'b1; inj_wdata = 3'd7;
      @(negedge clk);
      start = 1'b0; inj_wr = 1'b0;
      chk("R7", "rot_code not restarted", int'(rot_code != 4'd0), 1);
      chk("R8", "clamp during sweep", int'(inj_level), 5);
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      chk("R7", "sweep completed once", int'(ok), 1);
      chk("R5", "best_code after restart attempts", int'(best_code), 5);

      // R1 reset mid-sweep returns to code 0
      pulse_start();
      repeat (15) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "rot_code after reset", int'(rot_code), 0);
      chk("R1", "inj_level after reset", int'(inj_level), 0);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule